// File: doc/BRIEF.md
# Boot ROM overlay memory front end

This block sits between a small 8-bit processor core and a 64 KiB audio RAM with synchronous reads. It places a 64-byte boot ROM over the top 64 bytes of the address space. It gates RAM reads and RAM writes with control bits supplied from outside. For every access it also returns a speed code that the core uses to add wait states. The ROM covers reads only. A write into the ROM window always goes to RAM. When RAM is switched off, a read that the ROM does not serve returns a fixed filler byte rather than memory contents.

The core raises a one-cycle request with an address, a direction and write data. One clock later the block raises ready for one cycle. Read data and the speed code are valid only while ready is high. Requests may arrive on consecutive cycles. The ROM contents are computed when the design is built, so no memory file is needed.

Top module: `boot_overlay_fe`

## Requirements
- R1: After reset, ready is low. Ready goes high exactly one cycle after each request and stays high for that cycle only. With no request, ready is low on the next cycle.
- R2: When `rom_en`=1, a read whose address bits 15:6 are all ones returns ROM byte i, where i is address bits 5:0. ROM byte i is (29*i + 60) mod 256. No RAM read strobe is issued for such a read.
- R3: When `rom_en`=0, reads in the top 64-byte window are served like any other address: RAM data, or the filler byte when RAM is off.
- R4: A write into the top 64-byte window reaches RAM whatever the value of `rom_en`, provided R6 allows the write.
- R5: When `ram_off`=1, a read not served by the ROM returns 0x5A and issues no RAM read strobe.
- R6: The RAM write strobe is raised only for a write request while `ram_wr_en`=1 and `ram_off`=0. Any other write leaves RAM unchanged.
- R7: A read that the ROM does not serve, made while RAM is on, returns the RAM byte at the request address one cycle after the request.
- R8: The speed code shown with ready equals `clk_spd` for addresses 0x00F0-0x00FF and for reads served by the ROM. For every other access, including writes into the ROM window, it equals `ram_spd`. Both are sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with ready |
| cpu_ready | output | 1 | Access done, one cycle after the request |
| cpu_spd | output | 2 | Speed code of the completed access |
| rom_en | input | 1 | Boot ROM read overlay enable |
| ram_off | input | 1 | RAM disabled: reads give filler, writes blocked |
| ram_wr_en | input | 1 | RAM write permission |
| clk_spd | input | 2 | Speed code for register page and ROM reads |
| ram_spd | input | 2 | Speed code for RAM accesses |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe; data expected on `ram_rdata` next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
The properties assume that the control bits and both speed fields stay steady across the edge that accepts a request. They also assume the external RAM returns its data exactly one cycle after the read strobe. The bench meets both conditions: it changes the control bits only between accesses, with the request low, and its own RAM model registers read data on the clock edge that samples the strobe. Requests are driven on the falling edge and held for a single cycle. This keeps every request separate from the control-bit changes.

// File: rtl/bofe_pkg.sv
`timescale 1ns/1ps
package bofe_pkg;

  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_FILL = 2'd2
  } bofe_src_e;

  localparam int ROM_MUL = 29;
  localparam int ROM_OFS = 60;

  // Boot image byte at table index idx
  function automatic logic [7:0] rom_byte(input int idx);
    return 8'((idx * ROM_MUL + ROM_OFS) % 256);
  endfunction

endpackage

// File: rtl/bofe_rom.sv
`timescale 1ns/1ps
module bofe_rom #(
  parameter int ROM_AW = 6,
  parameter int DATA_W = 8
) (
  input  logic [ROM_AW-1:0] idx,
  output logic [DATA_W-1:0] q
);
  localparam int ROM_N = 1 << ROM_AW;

  logic [DATA_W-1:0] tbl [ROM_N];

  for (genvar g = 0; g < ROM_N; g++) begin : g_ent
    assign tbl[g] = DATA_W'(bofe_pkg::rom_byte(g));
  end

  assign q = tbl[idx];
endmodule

// File: rtl/bofe_decode.sv
`timescale 1ns/1ps
module bofe_decode
  import bofe_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          ROM_AW    = 6,
  parameter int          SPAN_W    = 4,
  parameter int          SPD_W     = 2,
  parameter int unsigned MMIO_BASE = 'h00F0
) (
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-SPAN_W-1:0] tag,
  input  logic                     rom_en,
  input  logic                     ram_off,
  input  logic                     ram_wr_en,
  input  logic [SPD_W-1:0]         clk_spd,
  input  logic [SPD_W-1:0]         ram_spd,
  output logic                     ram_re,
  output logic                     ram_we,
  output bofe_src_e                src,
  output logic [SPD_W-1:0]         spd
);
  localparam int TAG_W              = ADDR_W - SPAN_W;
  localparam int WIN_LO             = ROM_AW - SPAN_W;
  localparam logic [ADDR_W-1:0] MB  = ADDR_W'(MMIO_BASE);
  localparam logic [TAG_W-1:0] MTAG = MB[ADDR_W-1:SPAN_W];

  logic in_win, in_mmio, rom_hit;

  always_comb begin
    in_win  = &tag[TAG_W-1:WIN_LO];
    in_mmio = (tag == MTAG);
    rom_hit = !we && rom_en && in_win;

    if (rom_hit)      src = SRC_ROM;
    else if (ram_off) src = SRC_FILL;
    else              src = SRC_RAM;

    ram_re = req && !we && !rom_hit && !ram_off;
    ram_we = req && we && ram_wr_en && !ram_off;
    spd    = (in_mmio || rom_hit) ? clk_spd : ram_spd;
  end
endmodule

// File: rtl/bofe_rdpath.sv
`timescale 1ns/1ps
module bofe_rdpath
  import bofe_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          SPD_W  = 2,
  parameter int unsigned FILL   = 'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  bofe_src_e         src_d,
  input  logic [SPD_W-1:0]  spd_d,
  input  logic [DATA_W-1:0] rom_d,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [SPD_W-1:0]  spd
);
  localparam logic [DATA_W-1:0] FILL_B = DATA_W'(FILL);

  logic              rdy_q, rdy_n;
  bofe_src_e         src_q, src_n;
  logic [SPD_W-1:0]  spd_q, spd_n;
  logic [DATA_W-1:0] rom_q, rom_n;

  always_comb begin
    rdy_n = req;
    src_n = req ? src_d : src_q;
    spd_n = req ? spd_d : spd_q;
    rom_n = (req && src_d == SRC_ROM) ? rom_d : rom_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      src_q <= SRC_FILL;
      spd_q <= '0;
      rom_q <= '0;
    end else begin
      rdy_q <= rdy_n;
      src_q <= src_n;
      spd_q <= spd_n;
      rom_q <= rom_n;
    end
  end

  always_comb begin
    case (src_q)
      SRC_ROM:  rdata = rom_q;
      SRC_RAM:  rdata = ram_q;
      default:  rdata = FILL_B;
    endcase
  end

  assign ready = rdy_q;
  assign spd   = spd_q;
endmodule

// File: rtl/boot_overlay_fe.sv
`timescale 1ns/1ps
module boot_overlay_fe
  import bofe_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          ROM_AW    = 6,
  parameter int          SPAN_W    = 4,
  parameter int          SPD_W     = 2,
  parameter int unsigned MMIO_BASE = 'h00F0,
  parameter int unsigned FILL      = 'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [SPD_W-1:0]  cpu_spd,
  input  logic              rom_en,
  input  logic              ram_off,
  input  logic              ram_wr_en,
  input  logic [SPD_W-1:0]  clk_spd,
  input  logic [SPD_W-1:0]  ram_spd,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bofe_src_e         src_d;
  logic [SPD_W-1:0]  spd_d;
  logic [DATA_W-1:0] rom_d;

  bofe_decode #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .SPAN_W(SPAN_W),
    .SPD_W(SPD_W), .MMIO_BASE(MMIO_BASE)
  ) u_decode (
    .req      (cpu_req),
    .we       (cpu_we),
    .tag      (cpu_addr[ADDR_W-1:SPAN_W]),
    .rom_en   (rom_en),
    .ram_off  (ram_off),
    .ram_wr_en(ram_wr_en),
    .clk_spd  (clk_spd),
    .ram_spd  (ram_spd),
    .ram_re   (ram_re),
    .ram_we   (ram_we),
    .src      (src_d),
    .spd      (spd_d)
  );

  bofe_rom #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_rom (
    .idx(cpu_addr[ROM_AW-1:0]),
    .q  (rom_d)
  );

  bofe_rdpath #(.DATA_W(DATA_W), .SPD_W(SPD_W), .FILL(FILL)) u_rdpath (
    .clk  (clk),
    .rst_n(rst_q),
    .req  (cpu_req),
    .src_d(src_d),
    .spd_d(spd_d),
    .rom_d(rom_d),
    .ram_q(ram_rdata),
    .ready(cpu_ready),
    .rdata(cpu_rdata),
    .spd  (cpu_spd)
  );

  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/boot_overlay_fe_chk.sv
`timescale 1ns/1ps
module boot_overlay_fe_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          ROM_AW    = 6,
  parameter int          SPAN_W    = 4,
  parameter int          SPD_W     = 2,
  parameter int unsigned MMIO_BASE = 'h00F0,
  parameter int unsigned FILL      = 'h5A
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_ready,
  input logic [SPD_W-1:0]  cpu_spd,
  input logic              rom_en,
  input logic              ram_off,
  input logic              ram_wr_en,
  input logic [SPD_W-1:0]  clk_spd,
  input logic [SPD_W-1:0]  ram_spd,
  input logic              ram_re,
  input logic              ram_we
);
  localparam logic [ADDR_W-1:0] MB = ADDR_W'(MMIO_BASE);

  logic win, mmio, rom_rd;
  assign win    = &cpu_addr[ADDR_W-1:ROM_AW];
  assign mmio   = (cpu_addr[ADDR_W-1:SPAN_W] == MB[ADDR_W-1:SPAN_W]);
  assign rom_rd = !cpu_we && rom_en && win;

  // R1
  req_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cpu_req |=> cpu_ready);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !cpu_req |=> !cpu_ready);

  // R2
  rom_data_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && rom_rd) |=>
      cpu_rdata == DATA_W'(bofe_pkg::rom_byte(int'($past(cpu_addr[ROM_AW-1:0])))));

  // R5
  fill_data_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && !cpu_we && ram_off && !rom_rd) |=> cpu_rdata == DATA_W'(FILL));

  // R2 R5
  no_ram_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ram_re |-> (!cpu_we && !ram_off && !rom_rd));

  // R6
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ram_we |-> (cpu_req && cpu_we && ram_wr_en && !ram_off));

  // R4
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && cpu_we && win && ram_wr_en && !ram_off) |-> ram_we);

  // R8
  fast_spd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && (mmio || rom_rd)) |=> cpu_spd == $past(clk_spd));

  // R8
  ram_spd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && !mmio && !rom_rd) |=> cpu_spd == $past(ram_spd));
endmodule

bind boot_overlay_fe boot_overlay_fe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW), .SPAN_W(SPAN_W),
  .SPD_W(SPD_W), .MMIO_BASE(MMIO_BASE), .FILL(FILL)
) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .cpu_req  (cpu_req),
  .cpu_we   (cpu_we),
  .cpu_addr (cpu_addr),
  .cpu_rdata(cpu_rdata),
  .cpu_ready(cpu_ready),
  .cpu_spd  (cpu_spd),
  .rom_en   (rom_en),
  .ram_off  (ram_off),
  .ram_wr_en(ram_wr_en),
  .clk_spd  (clk_spd),
  .ram_spd  (ram_spd),
  .ram_re   (ram_re),
  .ram_we   (ram_we)
);

// File: tb/boot_overlay_fe_bench.sv
`timescale 1ns/1ps
module boot_overlay_fe_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cpu_req, cpu_we, cpu_ready, rom_en, ram_off, ram_wr_en;
  logic [15:0] cpu_addr, ram_addr;
  logic [7:0]  cpu_wdata, cpu_rdata, ram_wdata, ram_q;
  logic [1:0]  cpu_spd, clk_spd, ram_spd;
  logic        ram_re, ram_we;

  boot_overlay_fe u_boot_overlay_fe (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cpu_spd(cpu_spd), .rom_en(rom_en),
    .ram_off(ram_off), .ram_wr_en(ram_wr_en), .clk_spd(clk_spd),
    .ram_spd(ram_spd), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_rdata(ram_q)
  );

  // RAM model: 1 KiB image indexed by address bits 9:0
  bit [7:0] mem [1024];
  bit       vld [1024];
  bit [7:0] ref_m [1024];
  bit       ref_v [1024];

  function automatic logic [7:0] seed(input int idx);
    return 8'(idx ^ 'hA5);
  endfunction

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr[9:0]] <= ram_wdata;
      vld[ram_addr[9:0]] <= 1'b1;
    end
    if (ram_re)
      ram_q <= vld[ram_addr[9:0]] ? mem[ram_addr[9:0]] : seed(int'(ram_addr[9:0]));
  end

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input int i);
    return 8'((i * 29 + 60) % 256);
  endfunction

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return ref_v[a[9:0]] ? ref_m[a[9:0]] : seed(int'(a[9:0]));
  endfunction

  function automatic bit in_win(input logic [15:0] a);
    return a[15:6] == 10'h3FF;
  endfunction

  function automatic bit in_mmio(input logic [15:0] a);
    return a[15:4] == 12'h00F;
  endfunction

  function automatic logic [15:0] addr_of(input int k);
    if (k < 64) return 16'hFFC0 + 16'(k);
    if (k < 80) return 16'h00F0 + 16'(k - 64);
    case (k)
      80:      return 16'h0000;
      81:      return 16'h1234;
      82:      return 16'h8000;
      default: return 16'hFFBF;
    endcase
  endfunction

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic [1:0] sp, output logic rdy);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    rdy = cpu_ready; rd = cpu_rdata; sp = cpu_spd;
    cpu_req = 1'b0; cpu_we = 1'b0;
    @(negedge clk);
    chk("R1 ready low after single request", {7'd0, cpu_ready}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, exp_d;
    logic [1:0] sp, exp_s;
    logic       rdy;
    logic [15:0] a;
    string       tg;

    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rom_en = 1'b1; ram_off = 1'b0; ram_wr_en = 1'b0; clk_spd = 2'd0; ram_spd = 2'd0;
    repeat (4) @(negedge clk);
    chk("R1 ready low in reset", {7'd0, cpu_ready}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready low after reset", {7'd0, cpu_ready}, 8'd0);
    chk("R6 no write strobe idle", {7'd0, ram_we}, 8'd0);
    chk("R5 no read strobe idle", {7'd0, ram_re}, 8'd0);

    // sweep every control combination over window, register page and others
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      rom_en = c[0]; ram_off = c[1]; ram_wr_en = c[2];
      clk_spd = 2'(c); ram_spd = ~2'(c);
      for (int k = 0; k < 84; k++) begin
        a = addr_of(k);
        exp_d = 8'(a[7:0] ^ 8'(c << 4) ^ 8'h3C);
        access(1'b1, a, exp_d, rd, sp, rdy);
        chk("R1 write ready", {7'd0, rdy}, 8'd1);
        exp_s = in_mmio(a) ? clk_spd : ram_spd;
        chk("R8 write speed", {6'd0, sp}, {6'd0, exp_s});
        if (ram_wr_en && !ram_off) begin
          ref_m[a[9:0]] = exp_d;
          ref_v[a[9:0]] = 1'b1;
        end

        access(1'b0, a, 8'h00, rd, sp, rdy);
        chk("R1 read ready", {7'd0, rdy}, 8'd1);
        if (rom_en && in_win(a)) begin
          exp_d = rom_exp(int'(a[5:0])); tg = "R2 ROM overlay read";
        end else if (ram_off) begin
          exp_d = 8'h5A; tg = "R5 filler read";
        end else begin
          exp_d = ref_rd(a);
          tg = in_win(a) ? "R3 R4 window RAM read" : "R7 RAM read";
        end
        chk(tg, rd, exp_d);
        exp_s = (in_mmio(a) || (rom_en && in_win(a))) ? clk_spd : ram_spd;
        chk("R8 read speed", {6'd0, sp}, {6'd0, exp_s});
      end
    end

    // readback: blocked writes left RAM unchanged, window writes landed
    @(negedge clk);
    rom_en = 1'b0; ram_off = 1'b0; ram_wr_en = 1'b0;
    for (int k = 0; k < 84; k++) begin
      a = addr_of(k);
      access(1'b0, a, 8'h00, rd, sp, rdy);
      chk(in_win(a) ? "R4 R6 window readback" : "R6 readback", rd, ref_rd(a));
    end

    // back-to-back requests
    @(negedge clk);
    rom_en = 1'b1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'hFFC5;
    @(negedge clk);
    chk("R1 first ready", {7'd0, cpu_ready}, 8'd1);
    chk("R2 back-to-back ROM", cpu_rdata, rom_exp(5));
    cpu_addr = 16'h1234;
    @(negedge clk);
    chk("R1 second ready", {7'd0, cpu_ready}, 8'd1);
    chk("R7 back-to-back RAM", cpu_rdata, ref_rd(16'h1234));
    cpu_req = 1'b0;
    @(negedge clk);
    chk("R1 ready drops", {7'd0, cpu_ready}, 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule